// File: doc/BRIEF.md
# Latched Event Bridge Interrupt Controller

This block is a second-level interrupt controller. It gathers up to 32 event sources and presents one level-sensitive interrupt line, which feeds a single input of a main interrupt controller. Each event input is first brought into the local clock domain by a two-flop synchroniser. A rising edge then sets a sticky bit in a pending-event register. A per-source enable register gates which pending bits drive the combined line, and that line is registered.

Software talks to the block over a single-cycle register bus. A read returns its data combinationally in the same cycle. The pending-event register is at offset 0x00 and the enable register is at offset 0x04. Software serves events from the lowest enabled pending bit upward. It acknowledges each one by writing a word that holds a 0 in that bit's position and 1s everywhere else, so the other pending bits stay set. The number of implemented sources is a parameter. Bit positions at or above that count do not exist in hardware.

Top module: `evt_bridge_intc`

## Requirements
- R1: After reset, the pending register (offset 0x00) and the enable register (offset 0x04) both read 0, and `irq_o` is low.
- R2: A 0-to-1 transition on `evt_i[k]` sets pending bit k. The bit becomes readable three rising clock edges after the input changes. An input held high does not set the bit again after it has been cleared.
- R3: A write to offset 0x00 clears each pending bit whose write-data bit is 0. Pending bits whose write-data bit is 1 keep their value, so a write of all ones changes nothing.
- R4: When a clearing write to offset 0x00 and a newly detected edge on the same source take effect in the same cycle, the pending bit ends up set.
- R5: A write to offset 0x04 loads the enable register, and it reads back at that offset. An enable bit of 1 lets the matching pending bit drive `irq_o`, and 0 blocks it.
- R6: A source whose enable bit is 0 still sets its pending bit. It does not drive `irq_o`.
- R7: `irq_o` is a register. It is high one clock after any bit of (pending AND enable) is set. It goes low one clock after the last such bit is cleared.
- R8: With `NUM_SRC` sources implemented, bits at positions `NUM_SRC` and above read as 0 in both registers. No write can set them.
- R9: Reads of any offset other than 0x00 or 0x04 return 0. Writes to such offsets change neither register.
- R10: Clearing one pending bit leaves every other pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Event inputs, asynchronous to clk |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| irq_o | output | 1 | Combined registered interrupt line |

## Verification
The assertions check the following on every cycle:
- a detected edge always lands in the pending register;
- a pending bit never clears without a write to offset 0x00;
- a clearing write leaves no bit set where the write data held 0;
- the enable register takes the implemented part of the written word;
- `irq_o` follows (pending AND enable) one clock later;
- no unimplemented bit ever reads as 1.

Some behaviours depend on timing between the event inputs and the bus, so only the bench scenarios can show them. These are:
- the three-edge synchroniser latency;
- that an input held high does not set its bit again;
- that an event wins over a clearing write in the same cycle;
- that the unused offsets have no effect.

// File: rtl/bintc_pkg.sv
package bintc_pkg;

  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFS_PEND = 8'h00;
  localparam logic [7:0] OFS_ENAB = 8'h04;

  // Bit vector with the lowest n positions set: the implemented sources.
  function automatic logic [DATA_W-1:0] impl_bits(int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Next value of one pending bit. A fresh edge always wins. Otherwise a
  // clearing write with a 0 in this position drops the bit.
  function automatic logic pend_next(logic cur, logic clr_wr, logic wbit, logic edge_seen);
    return edge_seen | (cur & ~(clr_wr & ~wbit));
  endfunction

endpackage

// File: rtl/bintc_sync_edge.sv
module bintc_sync_edge #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] meta_q;
  logic [NUM_SRC-1:0] sync_q;
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= evt_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

endmodule

// File: rtl/bintc_regs.sv
module bintc_regs
  import bintc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise,
  input  logic               clr_wr,
  input  logic               enab_wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  pend_q,
  output logic [DATA_W-1:0]  enab_q
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < NUM_SRC) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q[b] <= 1'b0;
          enab_q[b] <= 1'b0;
        end else begin
          pend_q[b] <= pend_next(pend_q[b], clr_wr, wdata[b], rise[b]);
          if (enab_wr) enab_q[b] <= wdata[b];
        end
      end
    end else begin : g_absent
      assign pend_q[b] = 1'b0;
      assign enab_q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/bintc_irq_out.sv
module bintc_irq_out
  import bintc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] active,
  output logic              irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |active;
  end

endmodule

// File: rtl/evt_bridge_intc.sv
module evt_bridge_intc
  import bintc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(OFS_ENAB);

  // Named internal events, also observed by the bound checker.
  logic [NUM_SRC-1:0] rise;
  logic               hit_pend;
  logic               hit_enab;
  logic               clr_wr;
  logic               enab_wr;
  logic [DATA_W-1:0]  pend_q;
  logic [DATA_W-1:0]  enab_q;
  logic [DATA_W-1:0]  active;

  assign hit_pend = bus_sel && (bus_addr == A_PEND);
  assign hit_enab = bus_sel && (bus_addr == A_ENAB);
  assign clr_wr   = hit_pend && bus_wr;
  assign enab_wr  = hit_enab && bus_wr;

  bintc_sync_edge #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .rise_o (rise)
  );

  bintc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .clr_wr  (clr_wr),
    .enab_wr (enab_wr),
    .wdata   (bus_wdata),
    .pend_q  (pend_q),
    .enab_q  (enab_q)
  );

  assign active = pend_q & enab_q;

  bintc_irq_out u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .irq_q  (irq_o)
  );

  always_comb begin
    if (hit_pend)      bus_rdata = pend_q;
    else if (hit_enab) bus_rdata = enab_q;
    else               bus_rdata = '0;
  end

endmodule

// File: rtl/bintc_chk.sv
module bintc_chk
  import bintc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] rise,
  input logic               clr_wr,
  input logic               enab_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [DATA_W-1:0]  pend_q,
  input logic [DATA_W-1:0]  enab_q,
  input logic [DATA_W-1:0]  active,
  input logic               irq_o
);

  localparam logic [DATA_W-1:0] IMPL = impl_bits(NUM_SRC);

  logic [DATA_W-1:0] rise_w;
  assign rise_w = DATA_W'(rise);

  // R2: a detected edge is present in the pending register on the next cycle
  a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((pend_q & $past(rise_w)) == $past(rise_w)));

  // R3: without a write to the pending offset no bit ever drops
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(pend_q) & ~pend_q) == '0));

  // R3/R10: a clearing write without a new edge leaves nothing set where data was 0
  a_r3_clear_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && rise_w == '0) |=> ((pend_q & ~$past(bus_wdata)) == '0));

  // R5: the enable register takes the implemented part of the written word
  a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    enab_wr |=> (enab_q == ($past(bus_wdata) & IMPL)));

  // R7: output follows enabled pending bits one clock later
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0) |=> irq_o);

  a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> !irq_o);

  // R8: unimplemented positions never read as 1
  a_r8_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~IMPL) == '0);

endmodule

bind evt_bridge_intc bintc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise      (rise),
  .clr_wr    (clr_wr),
  .enab_wr   (enab_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pend_q    (pend_q),
  .enab_q    (enab_q),
  .active    (active),
  .irq_o     (irq_o)
);

// File: tb/tb_evt_bridge_intc.sv
module tb_evt_bridge_intc;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 20;
  localparam int AW         = 8;
  localparam logic [31:0] IMPL = (32'h1 << NSRC) - 32'h1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] evt = '0;
  logic            sel = 1'b0;
  logic            wr = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_bridge_intc #(.NUM_SRC(NSRC), .ADDR_W(AW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .bus_sel   (sel),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive at a negedge, the write lands on the next posedge, return at the negedge after.
  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 pending after reset", 8'h00, 32'h0);
    expect_reg("R1 enable after reset", 8'h04, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_masked_edge();
    evt[3] = 1'b1;
    tick(2);
    expect_reg("R2 pending not yet set after two edges", 8'h00, 32'h0);
    tick(1);
    expect_reg("R2 R6 masked source latched", 8'h00, 32'h8);
    tick(1);
    check("R6 masked source keeps irq low", {31'b0, irq}, 32'h0);
    bus_write(8'h00, ~32'h8);
    tick(3);
    expect_reg("R2 held level does not re-set", 8'h00, 32'h0);
    evt[3] = 1'b0;
    tick(3);
  endtask

  task automatic t_enable_irq();
    bus_write(8'h04, 32'h8);
    expect_reg("R5 enable readback", 8'h04, 32'h8);
    evt[3] = 1'b1;
    tick(3);
    expect_reg("R5 pending set", 8'h00, 32'h8);
    check("R7 irq not yet high", {31'b0, irq}, 32'h0);
    tick(1);
    check("R7 irq high one clock later", {31'b0, irq}, 32'h1);
    bus_write(8'h00, 32'h0);
    check("R7 irq still high right after clear", {31'b0, irq}, 32'h1);
    tick(1);
    check("R7 irq low one clock after clear", {31'b0, irq}, 32'h0);
    evt[3] = 1'b0;
    tick(3);
  endtask

  task automatic t_independent();
    bus_write(8'h04, IMPL);
    evt[0] = 1'b1; evt[5] = 1'b1; evt[19] = 1'b1;
    tick(3);
    expect_reg("R2 three sources latched", 8'h00, 32'h0008_0021);
    bus_write(8'h00, 32'hFFFF_FFFF);
    expect_reg("R3 all-ones write keeps bits", 8'h00, 32'h0008_0021);
    bus_write(8'h00, ~32'h1);
    expect_reg("R10 lowest cleared, others kept", 8'h00, 32'h0008_0020);
    tick(1);
    check("R7 irq high while bits remain", {31'b0, irq}, 32'h1);
    bus_write(8'h00, ~32'h20);
    expect_reg("R10 second bit cleared alone", 8'h00, 32'h0008_0000);
    bus_write(8'h00, ~32'h0008_0000);
    tick(1);
    check("R7 irq low after last clear", {31'b0, irq}, 32'h0);
    evt = '0;
    tick(3);
  endtask

  task automatic t_collision();
    evt[7] = 1'b1;
    tick(3);
    evt[7] = 1'b0;
    tick(3);
    expect_reg("R4 bit set before collision", 8'h00, 32'h80);
    evt[7] = 1'b1;
    tick(2);
    bus_write(8'h00, 32'h0);
    expect_reg("R4 new edge wins over clear", 8'h00, 32'h80);
    bus_write(8'h00, 32'h0);
    expect_reg("R4 later clear works", 8'h00, 32'h0);
    evt[7] = 1'b0;
    tick(3);
  endtask

  task automatic t_absent();
    bus_write(8'h04, 32'hFFFF_FFFF);
    expect_reg("R8 enable upper bits absent", 8'h04, IMPL);
    bus_write(8'h00, 32'hFFFF_FFFF);
    expect_reg("R8 pending upper bits never set", 8'h00, 32'h0);
  endtask

  task automatic t_other_offset();
    evt[2] = 1'b1;
    tick(3);
    bus_write(8'h08, 32'h0);
    expect_reg("R9 stray write leaves pending", 8'h00, 32'h4);
    expect_reg("R9 stray write leaves enable", 8'h04, IMPL);
    expect_reg("R9 other offset reads zero", 8'h08, 32'h0);
    expect_reg("R9 offset 0x0C reads zero", 8'h0C, 32'h0);
    evt[2] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_masked_edge();
    t_enable_irq();
    t_independent();
    t_collision();
    t_absent();
    t_other_offset();
    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule